// File: doc/BRIEF.md
# Deferred-Check Interrupt Arbiter

This block arbitrates among fifteen prioritized interrupt channels. It keeps two pending words. The first is a fast word of freshly raised requests, whose most significant bit is the global disable flag (1 = disabled). The second is a slower word of parked requests. Devices raise a channel by OR-ing its bit into the fast word. An instruction-fetch sequencer pulses a check strobe once per emulated instruction.

The common case is cheap: when interrupts are enabled and nothing new is pending, the fast word is zero, and a single signed "greater than zero" test on it decides that nothing more has to happen. When that test passes, the block combines both pending words and masks them with the channel-active mask.

- If an active channel is pending, the block takes an interrupt. In the same cycle it reports the channel, the vector fetch address and a save-PC request with its fixed address.
- If no active channel is pending, the fresh bits are parked in the slow word and the sequencer is told to restart the instruction.

Parked bits are looked at again only when interrupts are re-enabled, because enabling merges the slow word back into the fast one.

Bit numbering puts bit 0 at the most significant end of each word. Channel c (1..15) is bit c. Channel 0 is the disable flag and never carries a request.

Top module: `irq_defer_arb`

## Requirements
- R1: After reset the fast word reads 16'h8000 (disabled, nothing pending) and the parked word reads 0. No take or restart is signalled.
- R2: A device set bit for channel c (1..15) appears in the fast word after the next clock edge. A set on bit 0 is ignored and never changes the disable flag.
- R3: A check while the fast word is not greater than zero as a signed value has no effect: no take, no restart, and no change to either word. This covers the disable flag being set or the fast word being zero.
- R4: A check with the fast word greater than zero, and a nonzero value for (fast OR parked) AND active, raises `take` for that one cycle only. `take_chan` is the lowest-numbered such channel, so channel 1 has the highest priority.
- R5: While `take` is high, `vec_addr` equals VEC_BASE + 15 - `take_chan`, `save_pc` is high, and `save_addr` equals SAVE_LOC.
- R6: After a take, the disable flag is set and the taken channel's bit is cleared in both words. All other bits are kept.
- R7: A passing check with no active pending channel raises `restart` for that cycle. After the edge the parked word holds the old (fast OR parked) value and the fast word is zero.
- R8: A disable command sets the disable flag. When enable and disable arrive in the same cycle, disable wins.
- R9: An enable command alone clears the disable flag and ORs the parked word into the fast word. The parked word is left unchanged.
- R10: When a device set and a take-clear hit the same channel bit in the same cycle, the bit remains set in the fast word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set | input | 16 | Device set requests, OR-ed into the fast word (bit 0 = MSB, ignored) |
| active | input | 16 | Channel active mask (bit c enables channel c) |
| en_cmd | input | 1 | Enable interrupts and merge parked requests |
| dis_cmd | input | 1 | Disable interrupts |
| check | input | 1 | Check strobe from the fetch sequencer |
| take | output | 1 | Interrupt taken (one-cycle pulse) |
| take_chan | output | 4 | Channel being taken |
| vec_addr | output | 16 | Vector fetch address |
| save_pc | output | 1 | Request to store the PC |
| save_addr | output | 16 | Address at which the PC is stored |
| restart | output | 1 | Restart the instruction after parking |
| pend_new | output | 16 | Fast pending word (bit 0 = disable flag) |
| pend_park | output | 16 | Parked pending word |

## Verification
A wrong fast word shows at the ports one cycle after it is written. It appears either on `pend_new` or on the `take`/`restart` decision of the next check. A lost parked bit is silent until the next enable: the enable merges it back into `pend_new`, and the following check takes the wrong channel or restarts instead of taking. The directed tests therefore go through a full park, re-enable and take sequence. They also cover a set arriving on the same cycle as a take, and the two ends of the priority order, where a wrong vector address shows up in the same cycle as `take`.

// File: rtl/irq_defer_pkg.sv
package irq_defer_pkg;

  typedef enum logic [1:0] {
    CHK_IDLE = 2'd0,
    CHK_TAKE = 2'd1,
    CHK_PARK = 2'd2
  } chk_act_e;

  // Vector offset: highest channel maps to offset 0
  function automatic int unsigned vec_offset(input int unsigned top_chan,
                                             input int unsigned chan);
    return top_chan - chan;
  endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input  logic [0:W-1]  req,
  output logic [0:W-1]  onehot,
  output logic [CW-1:0] idx,
  output logic          found
);

  logic seen;

  // Lowest index wins
  always_comb begin
    onehot = '0;
    idx    = '0;
    seen   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req[i] && !seen) begin
        onehot[i] = 1'b1;
        idx       = CW'(i);
        seen      = 1'b1;
      end
    end
  end

  assign found = |req;

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int W = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040,
  localparam int CW = $clog2(W)
) (
  input  logic [CW-1:0] chan,
  output logic [AW-1:0] addr
);
  import irq_defer_pkg::*;

  assign addr = VEC_BASE + AW'(vec_offset(W - 1, int'(chan)));

endmodule

// File: rtl/irq_defer_arb.sv
module irq_defer_arb #(
  parameter int W = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040,
  parameter logic [AW-1:0] SAVE_LOC = 16'h0010,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [0:W-1]  dev_set,
  input  logic [0:W-1]  active,
  input  logic          en_cmd,
  input  logic          dis_cmd,
  input  logic          check,
  output logic          take,
  output logic [CW-1:0] take_chan,
  output logic [AW-1:0] vec_addr,
  output logic          save_pc,
  output logic [AW-1:0] save_addr,
  output logic          restart,
  output logic [0:W-1]  pend_new,
  output logic [0:W-1]  pend_park
);
  import irq_defer_pkg::*;

  logic [0:W-1] nww_q, ww_q, nww_d, ww_d;
  logic [0:W-1] chan_mask;
  logic [0:W-1] masked;
  logic [0:W-1] pick_oh;
  logic         ready;
  logic         found;
  chk_act_e     act;

  assign chan_mask = {1'b0, {(W-1){1'b1}}};

  // Signed greater-than-zero test on the natural word
  assign ready  = $signed(nww_q) > $signed({W{1'b0}});
  assign masked = (nww_q | ww_q) & active & chan_mask;

  irq_prio_enc #(.W(W)) u_pick (
    .req    (masked),
    .onehot (pick_oh),
    .idx    (take_chan),
    .found  (found)
  );

  irq_vec_gen #(.W(W), .AW(AW), .VEC_BASE(VEC_BASE)) u_vec (
    .chan (take_chan),
    .addr (vec_addr)
  );

  always_comb begin
    act = CHK_IDLE;
    if (check && ready) act = found ? CHK_TAKE : CHK_PARK;
  end

  always_comb begin
    nww_d = nww_q;
    ww_d  = ww_q;
    unique case (act)
      CHK_TAKE: begin
        nww_d = nww_q & ~pick_oh;
        ww_d  = ww_q & ~pick_oh;
      end
      CHK_PARK: begin
        ww_d  = nww_q | ww_q;
        nww_d = '0;
      end
      default: ;
    endcase
    if (dis_cmd || act == CHK_TAKE) begin
      nww_d[0] = 1'b1;
    end else if (en_cmd) begin
      nww_d    = nww_d | ww_d;
      nww_d[0] = 1'b0;
    end
    // Device sets applied last: a set beats a clear
    nww_d = nww_d | (dev_set & chan_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nww_q <= {1'b1, {(W-1){1'b0}}};
      ww_q  <= '0;
    end else begin
      nww_q <= nww_d;
      ww_q  <= ww_d;
    end
  end

  assign take      = (act == CHK_TAKE);
  assign restart   = (act == CHK_PARK);
  assign save_pc   = take;
  assign save_addr = SAVE_LOC;
  assign pend_new  = nww_q;
  assign pend_park = ww_q;

endmodule

// File: rtl/irq_defer_arb_chk.sv
module irq_defer_arb_chk #(
  parameter int W = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040,
  localparam int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [0:W-1]  dev_set,
  input logic [0:W-1]  active,
  input logic          dis_cmd,
  input logic          check,
  input logic          take,
  input logic [CW-1:0] take_chan,
  input logic [AW-1:0] vec_addr,
  input logic          restart,
  input logic [0:W-1]  pend_new,
  input logic [0:W-1]  pend_park,
  input logic [0:W-1]  pick_oh
);

  logic [0:W-1] set_bits;
  assign set_bits = dev_set & {1'b0, {(W-1){1'b1}}};

  assert_pick_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  assert_take_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (active[take_chan] && (pend_new[take_chan] || pend_park[take_chan])
              && take_chan != '0));

  assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_addr >= VEC_BASE && vec_addr <= VEC_BASE + AW'(W - 2)));

  assert_blocked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (check && pend_new[0]) |-> (!take && !restart));

  assert_take_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pend_new[0]);

  assert_no_take_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && restart));

  assert_park_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pend_park == $past(pend_new | pend_park)));

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> pend_new[0]);

  assert_set_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((pend_new & $past(set_bits)) == $past(set_bits)));

endmodule

bind irq_defer_arb irq_defer_arb_chk #(.W(W), .AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_set   (dev_set),
  .active    (active),
  .dis_cmd   (dis_cmd),
  .check     (check),
  .take      (take),
  .take_chan (take_chan),
  .vec_addr  (vec_addr),
  .restart   (restart),
  .pend_new  (pend_new),
  .pend_park (pend_park),
  .pick_oh   (pick_oh)
);

// File: tb/irq_defer_arb_test.sv
`timescale 1ns/100ps
module irq_defer_arb_test;

  localparam logic [15:0] VBASE = 16'h0040;
  localparam logic [15:0] SLOC  = 16'h0010;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [0:15] dev_set, active;
  logic        en_cmd, dis_cmd, check;
  logic        take, save_pc, restart;
  logic [3:0]  take_chan;
  logic [15:0] vec_addr, save_addr;
  logic [0:15] pend_new, pend_park;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_defer_arb #(.VEC_BASE(VBASE), .SAVE_LOC(SLOC)) uut (
    .clk(clk), .rst_n(rst_n), .dev_set(dev_set), .active(active),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .check(check),
    .take(take), .take_chan(take_chan), .vec_addr(vec_addr),
    .save_pc(save_pc), .save_addr(save_addr), .restart(restart),
    .pend_new(pend_new), .pend_park(pend_park)
  );

  function automatic logic [0:15] ch(input int c);
    return 16'h8000 >> c;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    dev_set = '0; active = '0; en_cmd = 0; dis_cmd = 0; check = 0;
  endtask

  // Advance one clock; returns at the following falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "pend_new", pend_new, 16'h8000);
    chk("R1", "pend_park", pend_park, 16'h0000);
    chk("R1", "take", take, 0);
    chk("R1", "restart", restart, 0);
  endtask

  task automatic t_blocked();
    dev_set = ch(3); active = 16'hFFFF; check = 1;
    #1;
    chk("R3", "take while disabled", take, 0);
    chk("R3", "restart while disabled", restart, 0);
    tick(); idle();
    chk("R2", "set ch3", pend_new, 16'h9000);
    chk("R3", "park untouched", pend_park, 16'h0000);
  endtask

  task automatic t_enable_set();
    en_cmd = 1; dev_set = ch(0) | ch(5);
    tick(); idle();
    chk("R9", "enable clears flag", pend_new, 16'h1400);
  endtask

  task automatic t_take_priority();
    active = ch(3) | ch(5); check = 1;
    #1;
    chk("R4", "take", take, 1);
    chk("R4", "lowest channel", take_chan, 3);
    chk("R5", "vector", vec_addr, VBASE + 16'd12);
    chk("R5", "save_pc", save_pc, 1);
    chk("R5", "save_addr", save_addr, SLOC);
    chk("R7", "no restart on take", restart, 0);
    tick(); idle();
    chk("R6", "fast after take", pend_new, 16'h8400);
    chk("R6", "park after take", pend_park, 16'h0000);
    #1;
    chk("R4", "pulse ended", take, 0);
  endtask

  task automatic t_park();
    en_cmd = 1;
    tick(); idle();
    chk("R9", "enable", pend_new, 16'h0400);
    active = ch(2); check = 1;
    #1;
    chk("R7", "restart", restart, 1);
    chk("R7", "no take", take, 0);
    tick(); idle();
    chk("R7", "parked", pend_park, 16'h0400);
    chk("R7", "fast cleared", pend_new, 16'h0000);
    active = 16'hFFFF; check = 1;
    #1;
    chk("R3", "zero word take", take, 0);
    chk("R3", "zero word restart", restart, 0);
    tick(); idle();
    chk("R3", "zero word park kept", pend_park, 16'h0400);
  endtask

  task automatic t_reenable();
    en_cmd = 1;
    tick(); idle();
    chk("R9", "merge parked", pend_new, 16'h0400);
    chk("R9", "park kept", pend_park, 16'h0400);
    active = ch(5); check = 1;
    #1;
    chk("R4", "take parked ch5", take, 1);
    chk("R4", "chan 5", take_chan, 5);
    chk("R5", "vector ch5", vec_addr, VBASE + 16'd10);
    tick(); idle();
    chk("R6", "fast cleared", pend_new, 16'h8000);
    chk("R6", "park cleared", pend_park, 16'h0000);
  endtask

  task automatic t_en_dis();
    en_cmd = 1; dis_cmd = 1;
    tick(); idle();
    chk("R8", "disable wins", pend_new, 16'h8000);
    en_cmd = 1;
    tick(); idle();
    chk("R9", "enable empty", pend_new, 16'h0000);
    dis_cmd = 1;
    tick(); idle();
    chk("R8", "disable", pend_new, 16'h8000);
  endtask

  task automatic t_set_wins();
    en_cmd = 1;
    tick(); idle();
    dev_set = ch(7);
    tick(); idle();
    chk("R2", "set ch7", pend_new, 16'h0100);
    active = ch(7); check = 1; dev_set = ch(7);
    #1;
    chk("R4", "take ch7", take_chan, 7);
    chk("R5", "vector ch7", vec_addr, VBASE + 16'd8);
    tick(); idle();
    chk("R10", "set beats clear", pend_new, 16'h8100);
  endtask

  task automatic t_last_chan();
    en_cmd = 1;
    tick(); idle();
    dev_set = ch(15);
    tick(); idle();
    chk("R2", "set ch15", pend_new, 16'h0101);
    active = ch(15); check = 1;
    #1;
    chk("R4", "take ch15", take, 1);
    chk("R4", "chan 15", take_chan, 15);
    chk("R5", "vector base", vec_addr, VBASE);
    tick(); idle();
    chk("R6", "ch7 kept", pend_new, 16'h8100);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_blocked();
    t_enable_set();
    t_take_priority();
    t_park();
    t_reenable();
    t_en_dis();
    t_set_wins();
    t_last_chan();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule